// File: doc/BRIEF.md
# Stop-and-Go Link Flow Control

This block joins a packet sender to a packet receiver over a pipelined data link and a one-bit reverse control link. Single-word flits enter the sender through a valid/ready port, travel through `DATA_LAT` register stages, and land in a receiver queue of `DEPTH` entries. A downstream consumer empties the queue through a valid/ready drain port.

The receiver watches its own occupancy and drives a single control bit back toward the sender. The bit turns to Stop once the fill level reaches a high watermark. It returns to Go only after the fill level has dropped to a separate, lower watermark, so it does not toggle on every flit near one level. The control bit takes `CTRL_LAT` register stages to reach the sender, which offers `in_ready` exactly while the last value it has seen is Go. Transfers are pipelined: there is no per-flit acknowledgement. Flits already on the wire when Stop is raised still arrive, so the high watermark is set low enough that the queue can absorb all of them.

Back-pressure rules: on the input side, a flit moves when `in_valid` and `in_ready` are both high at a rising clock edge, and `in_ready` never depends on `in_valid`. On the drain side, a flit moves when `out_valid` and `out_ready` are both high; while `out_valid` is high and `out_ready` is low, `out_data` holds steady.

Top module: `sg_link`

## Requirements
- R1: After reset `fill` is 0, `out_valid` is 0, `stop_out` is 0 (Go), `in_ready` is 1 and `ovf_err` is 0.
- R2: `in_ready` equals the inverse of the control bit as seen at the sender, and it does not depend on `in_valid`. A flit is taken only in a cycle where `in_valid` and `in_ready` are both 1.
- R3: `stop_out` (1 = Stop, 0 = Go) becomes 1 at the clock edge after a cycle in which `fill` is at or above `STOP_LVL`.
- R4: `stop_out` becomes 0 at the clock edge after a cycle in which `fill` is at or below `GO_LVL`. When `fill` lies strictly between the two watermarks, it keeps its value.
- R5: The sender sees the value of `stop_out` after exactly `CTRL_LAT` clock edges. `in_ready` in a cycle is the inverse of `stop_out` from `CTRL_LAT` cycles earlier.
- R6: A flit taken at a clock edge is written into the queue `DATA_LAT` edges later. `fill` rises by one at that edge, unless a drain happens at the same edge.
- R7: Flits leave through the drain port in the order they were taken, with none lost or duplicated.
- R8: `out_valid` is 1 exactly when `fill` is nonzero. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. A write and a drain at the same edge are both performed, even when the queue is full.
- R9: With `STOP_LVL` no larger than `DEPTH - (CTRL_LAT + DATA_LAT + 1)`, `fill` never exceeds `DEPTH` and the sticky `ovf_err` flag never sets. `ovf_err` would set if a flit arrived at a full queue with no drain at the same edge. With the default watermark, an unbroken input burst against a stalled drain brings `fill` to exactly `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sender side: a flit is offered |
| in_data | input | FLIT_W | Sender side: flit payload |
| in_ready | output | 1 | Sender side: the sender currently sees Go |
| out_valid | output | 1 | Drain side: queue head holds a flit |
| out_data | output | FLIT_W | Drain side: queue head payload |
| out_ready | input | 1 | Drain side: consumer takes the head flit |
| stop_out | output | 1 | Control bit as driven by the receiver, 1 = Stop |
| fill | output | $clog2(DEPTH+1) | Receiver queue occupancy |
| ovf_err | output | 1 | Sticky flag: a flit arrived at a full queue |

## Verification
The bench builds the link with its defaults: a 16-entry queue, three control stages and three data stages. These values give a 7-flit skid, a high watermark of 9 and a low watermark of 4. With this configuration a saturating burst against a stalled drain reaches exactly the queue depth. That makes the worst-case round trip a tight boundary, with no slack hiding an off-by-one. The three-stage delays on both links expose any miscounted register stage: the bench's cycle model of watermark, control delay and data delay would drift by a cycle. Random phases with varied offer and drain rates walk the fill level back and forth across both watermarks, which exercises the hysteresis band in both directions.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Encoding of the one-bit reverse control link.
  typedef enum logic {
    SG_GO   = 1'b0,
    SG_STOP = 1'b1
  } sg_ctrl_e;

  // Hysteresis decision: high watermark forces Stop, low watermark forces Go,
  // anything in between keeps the current indication.
  function automatic sg_ctrl_e sg_next_ctrl(input int unsigned level,
                                            input sg_ctrl_e    cur,
                                            input int unsigned hi_mark,
                                            input int unsigned lo_mark);
    if (level >= hi_mark)      return SG_STOP;
    else if (level <= lo_mark) return SG_GO;
    else                       return cur;
  endfunction

endpackage

// File: rtl/sg_pipe.sv
// Plain register delay line, STAGES deep, with a reset value.
module sg_pipe #(
  parameter int unsigned         W      = 1,
  parameter int unsigned         STAGES = 1,
  parameter logic [W-1:0]        RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST;
        else        stage_q[0] <= d;
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[i] <= RST;
          else        stage_q[i] <= stage_q[i-1];
        end
      end

      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sg_tx.sv
// Sender: injects a flit only while the received control bit reads Go.
module sg_tx
  import sg_pkg::*;
#(
  parameter int unsigned FLIT_W = 16
) (
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  output logic              in_ready,
  input  sg_ctrl_e          ctrl_seen,
  output logic              link_valid,
  output logic [FLIT_W-1:0] link_data
);

  assign in_ready   = (ctrl_seen == SG_GO);
  assign link_valid = in_valid && in_ready;
  assign link_data  = in_data;

endmodule

// File: rtl/sg_rxq.sv
// Receiver queue: circular buffer with a valid/ready drain and a sticky overflow flag.
module sg_rxq #(
  parameter int unsigned FLIT_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [FLIT_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic [FW-1:0]     level,
  output logic              ovf
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [FW-1:0]     cnt;
  logic              full, do_rd, do_wr, lost;

  assign full     = (cnt == FW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rd_ptr];
  assign do_rd    = rd_valid && rd_ready;
  assign lost     = wr_en && full && !do_rd;
  assign do_wr    = wr_en && !lost;
  assign level    = cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + FW'(1);
        2'b01:   cnt <= cnt - FW'(1);
        default: cnt <= cnt;
      endcase
      if (lost) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/sg_wmark.sv
// Occupancy watermark logic: registered Stop/Go with hysteresis.
module sg_wmark
  import sg_pkg::*;
#(
  parameter int unsigned FW       = 5,
  parameter int unsigned STOP_LVL = 9,
  parameter int unsigned GO_LVL   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] level,
  output sg_ctrl_e      ctrl
);

  sg_ctrl_e ctrl_d;

  always_comb ctrl_d = sg_next_ctrl(int'(level), ctrl, STOP_LVL, GO_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= SG_GO;
    else        ctrl <= ctrl_d;
  end

endmodule

// File: rtl/sg_link.sv
// Sender, pipelined data link, receiver queue and delayed reverse control bit.
module sg_link
  import sg_pkg::*;
#(
  parameter int unsigned FLIT_W   = 16,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned CTRL_LAT = 3,
  parameter int unsigned DATA_LAT = 3,
  parameter int unsigned STOP_LVL = DEPTH - (CTRL_LAT + DATA_LAT + 1),
  parameter int unsigned GO_LVL   = STOP_LVL / 2,
  localparam int unsigned FW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_data,
  input  logic              out_ready,
  output logic              stop_out,
  output logic [FW-1:0]     fill,
  output logic              ovf_err
);

  localparam int unsigned LINK_W = FLIT_W + 1;

  logic              tx_valid;
  logic [FLIT_W-1:0] tx_data;
  logic [LINK_W-1:0] link_far;
  sg_ctrl_e          rx_ctrl;
  logic [0:0]        ctrl_far;
  sg_ctrl_e          tx_ctrl;

  sg_tx #(.FLIT_W(FLIT_W)) u_tx (
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .ctrl_seen (tx_ctrl),
    .link_valid(tx_valid),
    .link_data (tx_data)
  );

  sg_pipe #(.W(LINK_W), .STAGES(DATA_LAT), .RST('0)) u_data_link (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({tx_valid, tx_data}),
    .q    (link_far)
  );

  sg_rxq #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (link_far[LINK_W-1]),
    .wr_data (link_far[FLIT_W-1:0]),
    .rd_valid(out_valid),
    .rd_data (out_data),
    .rd_ready(out_ready),
    .level   (fill),
    .ovf     (ovf_err)
  );

  sg_wmark #(.FW(FW), .STOP_LVL(STOP_LVL), .GO_LVL(GO_LVL)) u_wmark (
    .clk  (clk),
    .rst_n(rst_n),
    .level(fill),
    .ctrl (rx_ctrl)
  );

  sg_pipe #(.W(1), .STAGES(CTRL_LAT), .RST(1'(SG_GO))) u_ctrl_link (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'(rx_ctrl)),
    .q    (ctrl_far)
  );

  assign tx_ctrl  = sg_ctrl_e'(ctrl_far);
  assign stop_out = (rx_ctrl == SG_STOP);

endmodule

// File: rtl/sg_link_chk.sv
module sg_link_chk #(
  parameter int unsigned FLIT_W   = 16,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned STOP_LVL = 9,
  parameter int unsigned GO_LVL   = 4,
  parameter int unsigned FW       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_data,
  input logic              out_ready,
  input logic              stop_out,
  input logic [FW-1:0]     fill,
  input logic              ovf_err
);

  // R9: queue never overflows
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_err);

  // R9: occupancy bounded by depth
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // R3: Stop only raised after occupancy reached the high watermark
  a_r3_stop_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_out) |-> int'($past(fill)) >= STOP_LVL);

  // R4: Go only restored after occupancy fell to the low watermark
  a_r4_go_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_out) |-> int'($past(fill)) <= GO_LVL);

  // R6: occupancy moves by at most one per cycle
  a_r6_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (int'(fill) == int'($past(fill)) + 1) ||
    (int'(fill) + 1 == int'($past(fill))));

  // R8: stalled drain keeps its flit
  a_r8_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind sg_link sg_link_chk #(
  .FLIT_W(FLIT_W), .DEPTH(DEPTH), .STOP_LVL(STOP_LVL), .GO_LVL(GO_LVL), .FW(FW)
) u_sg_link_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ready(out_ready),
  .stop_out (stop_out),
  .fill     (fill),
  .ovf_err  (ovf_err)
);

// File: tb/tb_sg_link.sv
module tb_sg_link;

  localparam int CLK_PERIOD = 10;
  localparam int FLIT_W     = 16;
  localparam int DEPTH      = 16;
  localparam int CTRL_LAT   = 3;
  localparam int DATA_LAT   = 3;
  localparam int STOP_LVL   = DEPTH - (CTRL_LAT + DATA_LAT + 1);
  localparam int GO_LVL     = STOP_LVL / 2;
  localparam int FW         = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [FLIT_W-1:0] in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [FLIT_W-1:0] out_data;
  logic              out_ready = 1'b0;
  logic              stop_out;
  logic [FW-1:0]     fill;
  logic              ovf_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  sg_link #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .CTRL_LAT(CTRL_LAT), .DATA_LAT(DATA_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .stop_out(stop_out), .fill(fill), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model state
  int              fill_m = 0;
  bit              stop_m = 0;
  bit              cdl [CTRL_LAT];
  bit              ddv [DATA_LAT];
  logic [FLIT_W-1:0] ddd [DATA_LAT];
  logic [FLIT_W-1:0] sb [$];
  bit              fi = 0, fo = 0;
  logic [FLIT_W-1:0] fdata = '0;
  int              peak = 0;
  logic [FLIT_W-1:0] seq = 16'h1000;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit next_stop(input int lvl, input bit cur);
    if (lvl >= STOP_LVL) return 1'b1;
    if (lvl <= GO_LVL)   return 1'b0;
    return cur;
  endfunction

  // Advance the model across one rising edge, using the handshakes seen before it.
  task automatic model_edge();
    bit wr;
    logic [FLIT_W-1:0] wd;
    bit ns;
    wr = ddv[DATA_LAT-1];
    wd = ddd[DATA_LAT-1];
    for (int i = DATA_LAT-1; i > 0; i--) begin
      ddv[i] = ddv[i-1];
      ddd[i] = ddd[i-1];
    end
    ddv[0] = fi;
    ddd[0] = fdata;
    for (int i = CTRL_LAT-1; i > 0; i--) cdl[i] = cdl[i-1];
    cdl[0] = stop_m;
    ns = next_stop(fill_m, stop_m);
    if (wr) sb.push_back(wd);
    fill_m = fill_m + int'(wr) - int'(fo);
    stop_m = ns;
    if (fill_m > peak) peak = fill_m;
  endtask

  task automatic check_outputs();
    check("R6", "fill", int'(fill), fill_m);
    check("R3", "stop_out", int'(stop_out), int'(stop_m));
    check("R5", "in_ready", int'(in_ready), int'(!cdl[CTRL_LAT-1]));
    check("R8", "out_valid", int'(out_valid), int'(fill_m != 0));
    check("R9", "ovf_err", int'(ovf_err), 0);
  endtask

  // One cycle: model the last edge, check, drive, record handshakes.
  task automatic cycle(input int pv, input int pr);
    @(negedge clk);
    model_edge();
    check_outputs();
    in_valid  = ($urandom_range(99) < pv);
    if (in_valid) begin
      seq = seq + 16'h0001;
      in_data = seq ^ 16'(($urandom & 32'h00f0));
    end else begin
      in_data = 16'($urandom);
    end
    out_ready = ($urandom_range(99) < pr);
    #1;
    // R2: readiness must not follow in_valid
    check("R2", "in_ready vs model", int'(in_ready), int'(!cdl[CTRL_LAT-1]));
    fi    = in_valid && in_ready;
    fdata = in_data;
    fo    = out_valid && out_ready;
    if (fo) begin
      if (sb.size() == 0) begin
        check("R7", "drain with empty model", 1, 0);
      end else begin
        check("R7", "drain order", int'(out_data), int'(sb[0]));
        void'(sb.pop_front());
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int first_fall_seen;
    int prev_stop;
    void'($urandom(32'h0005eed5));
    for (int i = 0; i < CTRL_LAT; i++) cdl[i] = 1'b0;
    for (int i = 0; i < DATA_LAT; i++) begin
      ddv[i] = 1'b0;
      ddd[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "fill", int'(fill), 0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "stop_out", int'(stop_out), 0);
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "ovf_err", int'(ovf_err), 0);
    // R2: in_valid toggled during reset-Go must not change in_ready
    in_valid = 1'b1;
    #1;
    check("R2", "in_ready with in_valid", int'(in_ready), 1);
    in_valid = 1'b0;
    rst_n = 1'b1;
    fi = 0;
    fo = 0;

    // Directed: saturate input against a stalled drain (worst round trip)
    for (int c = 0; c < 40; c++) cycle(100, 0);
    // R9: peak reaches exactly DEPTH with the default watermark
    check("R9", "peak fill on burst", peak, DEPTH);
    check("R3", "stop held when full", int'(stop_out), 1);

    // Directed: drain with no input, Go must return at the low watermark
    prev_stop = 1;
    first_fall_seen = 0;
    for (int c = 0; c < 30; c++) begin
      cycle(0, 100);
      if (prev_stop == 1 && stop_out == 1'b0 && first_fall_seen == 0) begin
        first_fall_seen = 1;
        // R4: fell at edge after fill <= GO_LVL; one drain per edge since
        check("R4", "fill at Go return", int'(fill), GO_LVL - 1);
      end
      prev_stop = int'(stop_out);
    end
    check("R4", "Go seen during drain", first_fall_seen, 1);
    check("R8", "empty after drain", int'(out_valid), 0);

    // Random phases with varied offer and drain rates
    for (int c = 0; c < 600; c++) cycle(50, 50);
    for (int c = 0; c < 600; c++) cycle(90, 30);
    for (int c = 0; c < 400; c++) cycle(95, 60);
    for (int c = 0; c < 400; c++) cycle(30, 90);
    // Full queue with simultaneous write and drain (R8)
    for (int c = 0; c < 40; c++) cycle(100, 0);
    for (int c = 0; c < 40; c++) cycle(100, 100);
    for (int c = 0; c < 60; c++) cycle(0, 100);
    check("R7", "all flits delivered", sb.size(), 0);
    check("R9", "peak never above depth", int'(peak <= DEPTH), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule